// File: doc/BRIEF.md
# Multichannel Conversion Scheduler With Ready Flags

This block is the digital sequencer for a converter that runs continuously over up to eight input channels. The host programs a cycle count for each channel and a mask of enabled channels, then issues a mode command that carries a starting channel. From then on the block converts each enabled channel in turn, for that channel's programmed number of cycles. At the end of each conversion it captures the word present on the sample input into that channel's result register.

Each channel has an unread flag. The flag is set when a result lands and cleared when the host reads the channel. An active-low ready pin summarises the flags under one of two policies: it is low when any channel is unread, or it is low only when every enabled channel is unread.

Two hazards have fixed outcomes:
- A result that replaces an unread one is stored, but its flag is hidden and the pin is held high for a fixed hold-off period.
- A result that completes while the host is reading that same channel is thrown away.

Top module: `multichan_conv_sched`

## Requirements
- R1: After reset all result registers read 0, `flags_o` is 0 and `rdy_no` is 1. Any mode write clears every flag, and `rdy_no` is 1 from the edge that captures the write.
- R2: A mode write with `mode_cont_i`=1 starts a conversion on `mode_chan_i` at the capturing edge, even if that channel is not enabled. That conversion completes max(T,1) edges later, where T is that channel's programmed time.
- R3: After each completion the next channel is the first enabled one above the current one, wrapping from channel 7 to channel 0. A programmed time of 0 lasts one cycle.
- R4: A completion stores the `sample_i` value present at the completing edge into that channel's register and sets `flags_o[n]` for channel n. `rd_data_o` always shows the register selected by `rd_chan_i`.
- R5: A cycle with `rd_i`=1 clears the flag of channel `rd_chan_i` at that edge.
- R6: With `rdy_all_i`=0, `rdy_no` is low one cycle after any visible flag is set, outside a hold-off.
- R7: With `rdy_all_i`=1, `rdy_no` is low only one cycle after every enabled channel shows its flag. It is high while the enable mask is 0.
- R8: A completion on a channel whose flag is still set stores the new word, hides that flag and forces `rdy_no` high at once. After 163 edges the flag reappears, and the pin follows its policy on the next edge.
- R9: When `rd_i` names the channel completing in that same cycle, the old word is kept and the new one is dropped.
- R10: While the enable mask is 0, and after a mode write with `mode_cont_i`=0, no conversion completes and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_cont_i | input | 1 | 1 = continuous command, 0 = idle |
| mode_chan_i | input | 3 | Start channel for the mode command |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_i | input | 8 | Enable mask, bit n = channel n |
| time_wr_i | input | 1 | Conversion time write strobe |
| time_chan_i | input | 3 | Channel whose time is written |
| time_i | input | 16 | Conversion time in cycles |
| rdy_all_i | input | 1 | Ready pin policy: 0 = any unread, 1 = all enabled unread |
| sample_i | input | 24 | Result word captured at conversion end |
| rd_i | input | 1 | Read strobe, clears the selected flag |
| rd_chan_i | input | 3 | Channel selected for reading |
| rd_data_o | output | 24 | Result register of `rd_chan_i` |
| flags_o | output | 8 | Visible unread flags |
| rdy_no | output | 1 | Ready pin, active low |

## Verification
The two functions that can fall in one cycle are a host read and a conversion completing on the same channel. The bench provokes this by raising the read strobe in the cycle just before a completion edge it has computed in advance. It then expects the earlier word to survive and the flag to end cleared. A second overlap, an overwrite landing while an earlier hold-off is running, is covered by random runs with short conversion times. There the bench judges only the stored words against a schedule it computes itself.

// File: rtl/conv_sched_pkg.sv
`timescale 1ns/1ps
package conv_sched_pkg;
  localparam int unsigned DEF_NCH  = 8;
  localparam int unsigned DEF_DW   = 24;
  localparam int unsigned DEF_TW   = 16;
  localparam int unsigned DEF_HOLD = 163;

  typedef enum logic {
    MODE_IDLE = 1'b0,
    MODE_CONT = 1'b1
  } mode_e;
endpackage

// File: rtl/conv_cfg.sv
`timescale 1ns/1ps
module conv_cfg #(
  parameter int unsigned NCH = 8,
  parameter int unsigned TW  = 16,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mask_wr_i,
  input  logic [NCH-1:0]          mask_i,
  input  logic                    time_wr_i,
  input  logic [CW-1:0]           time_chan_i,
  input  logic [TW-1:0]           time_i,
  output logic [NCH-1:0]          mask_o,
  output logic [NCH-1:0][TW-1:0]  time_o
);
  logic [NCH-1:0]         mask_q;
  logic [NCH-1:0][TW-1:0] time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_wr_i) begin
      mask_q <= mask_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_time
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        time_q[g] <= '0;
      end else if (time_wr_i && (time_chan_i == CW'(g))) begin
        time_q[g] <= time_i;
      end
    end
  end

  assign mask_o = mask_q;
  assign time_o = time_q;
endmodule

// File: rtl/conv_seq.sv
`timescale 1ns/1ps
module conv_seq
  import conv_sched_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned TW  = 16,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_wr_i,
  input  logic                   mode_cont_i,
  input  logic [CW-1:0]          mode_chan_i,
  input  logic [NCH-1:0]         mask_i,
  input  logic [NCH-1:0][TW-1:0] time_i,
  output logic                   done_o,
  output logic [CW-1:0]          cur_o
);
  logic          run_q;
  logic [CW-1:0] cur_q, nxt;
  logic [TW-1:0] cnt_q, tsel, lim;

  assign tsel = time_i[cur_q];
  // zero programmed time behaves as one cycle
  assign lim  = (tsel == '0) ? '0 : tsel - TW'(1);

  assign done_o = run_q && (|mask_i) && (cnt_q >= lim) && !mode_wr_i;

  // first enabled channel above cur_q, wrapping; cur_q itself if it is the only one
  always_comb begin
    logic found;
    int unsigned j;
    nxt   = cur_q;
    found = 1'b0;
    for (int unsigned k = 1; k <= NCH; k++) begin
      j = (int'(cur_q) + k) % NCH;
      if (!found && mask_i[j]) begin
        nxt   = CW'(j);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cur_q <= '0;
      cnt_q <= '0;
    end else if (mode_wr_i) begin
      run_q <= (mode_e'(mode_cont_i) == MODE_CONT);
      cur_q <= mode_chan_i;
      cnt_q <= '0;
    end else if (run_q && (|mask_i)) begin
      if (done_o) begin
        cur_q <= nxt;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/conv_store.sv
`timescale 1ns/1ps
module conv_store #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned DW   = 24,
  parameter int unsigned HOLD = 163,
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned HW  = $clog2(HOLD + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_wr_i,
  input  logic           done_i,
  input  logic [CW-1:0]  cur_i,
  input  logic [DW-1:0]  sample_i,
  input  logic           rd_i,
  input  logic [CW-1:0]  rd_chan_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [NCH-1:0] flags_o,
  output logic           ovw_o,
  output logic           hold_busy_o
);
  logic [DW-1:0]  data_q [NCH];
  logic [NCH-1:0] unread_q, hide_q, hit, rdh;
  logic [HW-1:0]  hold_q;
  logic           collide, store, hold_end;

  assign collide = done_i && rd_i && (rd_chan_i == cur_i);
  assign store   = done_i && !collide;
  assign ovw_o   = store && unread_q[cur_i];
  assign hold_end = (hold_q == HW'(1)) && !ovw_o;

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign hit[g] = store && (cur_i == CW'(g));
    assign rdh[g] = rd_i && (rd_chan_i == CW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) data_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (hit[i]) data_q[i] <= sample_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unread_q <= '0;
      hide_q   <= '0;
      hold_q   <= '0;
    end else if (mode_wr_i) begin
      unread_q <= '0;
      hide_q   <= '0;
      hold_q   <= '0;
    end else begin
      unread_q <= (unread_q & ~rdh) | hit;
      hide_q   <= ((hold_end ? '0 : hide_q) & ~rdh) | (ovw_o ? hit : '0);
      if (ovw_o)              hold_q <= HW'(HOLD);
      else if (hold_q != '0)  hold_q <= hold_q - HW'(1);
    end
  end

  assign rd_data_o   = data_q[rd_chan_i];
  assign flags_o     = unread_q & ~hide_q;
  assign hold_busy_o = (hold_q != '0);
endmodule

// File: rtl/conv_rdy_pin.sv
`timescale 1ns/1ps
module conv_rdy_pin #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] flags_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           all_i,
  input  logic           hold_busy_i,
  input  logic           force_i,
  output logic           rdy_no
);
  logic low, any_low, all_low, rdy_n_q;

  assign any_low = |flags_i;
  assign all_low = (|mask_i) && ((flags_i & mask_i) == mask_i);
  assign low     = !hold_busy_i && (all_i ? all_low : any_low);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdy_n_q <= 1'b1;
    else if (force_i) rdy_n_q <= 1'b1;
    else              rdy_n_q <= !low;
  end

  assign rdy_no = rdy_n_q;
endmodule

// File: rtl/multichan_conv_sched.sv
`timescale 1ns/1ps
module multichan_conv_sched
  import conv_sched_pkg::*;
#(
  parameter int unsigned NCH  = DEF_NCH,
  parameter int unsigned DW   = DEF_DW,
  parameter int unsigned TW   = DEF_TW,
  parameter int unsigned HOLD = DEF_HOLD,
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_wr_i,
  input  logic           mode_cont_i,
  input  logic [CW-1:0]  mode_chan_i,
  input  logic           mask_wr_i,
  input  logic [NCH-1:0] mask_i,
  input  logic           time_wr_i,
  input  logic [CW-1:0]  time_chan_i,
  input  logic [TW-1:0]  time_i,
  input  logic           rdy_all_i,
  input  logic [DW-1:0]  sample_i,
  input  logic           rd_i,
  input  logic [CW-1:0]  rd_chan_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [NCH-1:0] flags_o,
  output logic           rdy_no
);
  logic [NCH-1:0]         mask;
  logic [NCH-1:0][TW-1:0] times;
  logic                   done, ovw, hold_busy;
  logic [CW-1:0]          cur;

  conv_cfg #(.NCH(NCH), .TW(TW)) u_cfg (
    .clk_i, .rst_ni,
    .mask_wr_i, .mask_i,
    .time_wr_i, .time_chan_i, .time_i,
    .mask_o(mask), .time_o(times)
  );

  conv_seq #(.NCH(NCH), .TW(TW)) u_seq (
    .clk_i, .rst_ni,
    .mode_wr_i, .mode_cont_i, .mode_chan_i,
    .mask_i(mask), .time_i(times),
    .done_o(done), .cur_o(cur)
  );

  conv_store #(.NCH(NCH), .DW(DW), .HOLD(HOLD)) u_store (
    .clk_i, .rst_ni,
    .mode_wr_i, .done_i(done), .cur_i(cur), .sample_i,
    .rd_i, .rd_chan_i, .rd_data_o, .flags_o,
    .ovw_o(ovw), .hold_busy_o(hold_busy)
  );

  conv_rdy_pin #(.NCH(NCH)) u_pin (
    .clk_i, .rst_ni,
    .flags_i(flags_o), .mask_i(mask), .all_i(rdy_all_i),
    .hold_busy_i(hold_busy), .force_i(mode_wr_i | ovw),
    .rdy_no
  );
endmodule

// File: rtl/conv_sched_chk.sv
`timescale 1ns/1ps
module conv_sched_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 24,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mode_wr_i,
  input logic           rd_i,
  input logic [CW-1:0]  rd_chan_i,
  input logic [DW-1:0]  rd_data_i,
  input logic [NCH-1:0] flags_i,
  input logic [NCH-1:0] mask_i,
  input logic           rdy_all_i,
  input logic           rdy_ni,
  input logic           done_i,
  input logic           ovw_i,
  input logic [CW-1:0]  cur_i
);
  AST_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (flags_i == '0) && rdy_ni); // R1

  AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !flags_i[$past(rd_chan_i)]); // R5

  AST_ANY_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_ni |-> $past(flags_i != '0)); // R6

  AST_ALL_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_ni && $past(rdy_all_i)) |-> $past((mask_i != '0) && ((flags_i & mask_i) == mask_i))); // R7

  AST_OVW_HIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovw_i |=> rdy_ni && !flags_i[$past(cur_i)]); // R8

  AST_COLLIDE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rd_i && (rd_chan_i == cur_i)) |=>
      (rd_chan_i != $past(rd_chan_i)) || (rd_data_i == $past(rd_data_i))); // R9

  AST_IDLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (mask_i != '0)); // R10
endmodule

bind multichan_conv_sched conv_sched_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i),
  .rd_i(rd_i), .rd_chan_i(rd_chan_i), .rd_data_i(rd_data_o),
  .flags_i(flags_o), .mask_i(mask), .rdy_all_i(rdy_all_i),
  .rdy_ni(rdy_no), .done_i(done), .ovw_i(ovw), .cur_i(cur)
);

// File: tb/tb_multichan_conv_sched.sv
`timescale 1ns/1ps
module tb_multichan_conv_sched;
  localparam int NCH = 8;
  localparam int CW  = 3;
  localparam int DW  = 24;
  localparam int TW  = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_wr_i = 0, mode_cont_i = 0, mask_wr_i = 0, time_wr_i = 0;
  logic rdy_all_i = 0, rd_i = 0;
  logic [CW-1:0]  mode_chan_i = '0, time_chan_i = '0, rd_chan_i = '0;
  logic [NCH-1:0] mask_i = '0;
  logic [TW-1:0]  time_i = '0;
  logic [DW-1:0]  sample_i = '0;
  logic [DW-1:0]  rd_data_o;
  logic [NCH-1:0] flags_o;
  logic           rdy_no;

  always #2.5 clk = ~clk;

  multichan_conv_sched dut (
    .clk_i(clk), .rst_ni, .mode_wr_i, .mode_cont_i, .mode_chan_i,
    .mask_wr_i, .mask_i, .time_wr_i, .time_chan_i, .time_i,
    .rdy_all_i, .sample_i, .rd_i, .rd_chan_i,
    .rd_data_o, .flags_o, .rdy_no
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit fin = 0;
  logic [DW-1:0] exp_data [NCH];
  int tb_times [NCH];

  function automatic logic [DW-1:0] mix(int n);
    logic [31:0] v;
    v = 32'(n) * 32'h9E3779B1;
    return DW'(v ^ (v >> 13));
  endfunction

  function automatic int tconv(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int nxt_ch(int c, logic [NCH-1:0] m);
    for (int k = 1; k <= NCH; k++) if (m[(c + k) % NCH]) return (c + k) % NCH;
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    sample_i = mix(cyc);
  endtask

  task automatic wait_n(int n);
    repeat (n) tick();
  endtask

  task automatic mode_cmd(bit c, int ch);
    mode_wr_i = 1; mode_cont_i = c; mode_chan_i = CW'(ch);
    tick();
    mode_wr_i = 0;
  endtask

  task automatic set_time(int ch, int t);
    time_wr_i = 1; time_chan_i = CW'(ch); time_i = TW'(t);
    tick();
    time_wr_i = 0;
  endtask

  task automatic set_mask(logic [NCH-1:0] m);
    mask_wr_i = 1; mask_i = m;
    tick();
    mask_wr_i = 0;
  endtask

  task automatic peek(int ch);
    rd_chan_i = CW'(ch);
    #1;
  endtask

  // schedule model: start edge s, first channel st, stop edge x (completion at x suppressed)
  task automatic model_run(int s, int st, logic [NCH-1:0] m, int x);
    int t, ch, d;
    t = s; ch = st;
    forever begin
      d = t + tconv(tb_times[ch]);
      if (d >= x) break;
      exp_data[ch] = mix(d - 1);
      ch = nxt_ch(ch, m);
      t = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s, x, st, len;
    logic [NCH-1:0] m;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin exp_data[i] = '0; tb_times[i] = 0; end
    wait_n(3);
    rst_ni = 1;
    tick();

    // reset state
    chk("R1 reset flags", 32'(flags_o), 0);
    chk("R1 reset pin", 32'(rdy_no), 1);
    peek(5);
    chk("R1 reset data", 32'(rd_data_o), 0);

    // constrained random runs, no reads while running
    for (int it = 0; it < 6; it++) begin
      for (int c = 0; c < NCH; c++) begin
        tb_times[c] = ($urandom % 6 == 0) ? 0 : 1 + int'($urandom % 30);
        set_time(c, tb_times[c]);
      end
      m = NCH'($urandom % 255 + 1);
      set_mask(m);
      st = int'($urandom % NCH);
      mode_cmd(1, st);
      s = cyc;
      len = 150 + int'($urandom % 300);
      wait_n(len);
      mode_cmd(0, 0);
      x = cyc;
      model_run(s, st, m, x);
      chk("R1 flags after idle", 32'(flags_o), 0);
      wait_n(10);
      for (int c = 0; c < NCH; c++) begin
        peek(c);
        chk("R2 R3 R4 R10 random data", 32'(rd_data_o), 32'(exp_data[c]));
      end
    end

    // zero time and wrap 7 -> 0
    set_time(7, 3); set_time(0, 0); set_mask(8'h81); rdy_all_i = 0;
    mode_cmd(1, 7); s = cyc;
    wait_n(3);
    chk("R2 first done on start channel", 32'(flags_o), 32'h80);
    peek(7);
    chk("R4 stored sample", 32'(rd_data_o), 32'(mix(s + 2)));
    chk("R6 pin lags flag", 32'(rdy_no), 1);
    wait_n(1);
    chk("R3 zero time wrap", 32'(flags_o), 32'h81);
    chk("R6 any unread low", 32'(rdy_no), 0);
    peek(0);
    chk("R3 zero time data", 32'(rd_data_o), 32'(mix(s + 3)));
    mode_cmd(0, 0);
    chk("R1 mode write clears", 32'(flags_o), 0);
    chk("R1 mode write pin", 32'(rdy_no), 1);
    wait_n(20);
    peek(0);
    chk("R10 idle keeps data", 32'(rd_data_o), 32'(mix(s + 3)));
    chk("R10 idle no flags", 32'(flags_o), 0);

    // overwrite hold-off
    set_time(0, 10); set_mask(8'h01);
    mode_cmd(1, 0); s = cyc;
    wait_n(10);
    chk("R4 flag set", 32'(flags_o), 1);
    wait_n(1);
    chk("R6 pin low", 32'(rdy_no), 0);
    wait_n(8);
    set_time(0, 1000);
    chk("R8 flag hidden", 32'(flags_o), 0);
    chk("R8 pin forced", 32'(rdy_no), 1);
    peek(0);
    chk("R8 new word stored", 32'(rd_data_o), 32'(mix(s + 19)));
    wait_n(162);
    chk("R8 still hidden", 32'(flags_o), 0);
    chk("R8 still high", 32'(rdy_no), 1);
    wait_n(1);
    chk("R8 flag back", 32'(flags_o), 1);
    chk("R8 pin high last", 32'(rdy_no), 1);
    wait_n(1);
    chk("R8 pin reasserts", 32'(rdy_no), 0);
    rd_i = 1; peek(0);
    chk("R5 read data", 32'(rd_data_o), 32'(mix(s + 19)));
    tick(); rd_i = 0;
    chk("R5 flag cleared", 32'(flags_o), 0);
    tick();
    chk("R5 pin high", 32'(rdy_no), 1);
    mode_cmd(0, 0);

    // read colliding with completion
    set_time(2, 4); set_mask(8'h04);
    mode_cmd(1, 2); s = cyc;
    wait_n(4);
    chk("R2 start ch2", 32'(flags_o), 32'h04);
    wait_n(3);
    rd_i = 1; rd_chan_i = 2;
    tick(); rd_i = 0;
    peek(2);
    chk("R9 old word kept", 32'(rd_data_o), 32'(mix(s + 3)));
    chk("R9 flag cleared", 32'(flags_o), 0);
    wait_n(4);
    chk("R9 next result flag", 32'(flags_o), 32'h04);
    peek(2);
    chk("R9 next result data", 32'(rd_data_o), 32'(mix(s + 11)));
    mode_cmd(0, 0);

    // all-enabled policy and empty mask
    set_time(1, 3); set_time(2, 5); set_mask(8'h06); rdy_all_i = 1;
    mode_cmd(1, 1); s = cyc;
    wait_n(4);
    chk("R7 partial flags", 32'(flags_o), 32'h02);
    chk("R7 partial pin high", 32'(rdy_no), 1);
    wait_n(5);
    chk("R7 full flags", 32'(flags_o), 32'h06);
    chk("R7 full pin low", 32'(rdy_no), 0);
    set_mask(8'h00);
    tick();
    chk("R7 empty mask high", 32'(rdy_no), 1);
    wait_n(40);
    chk("R10 empty mask flags", 32'(flags_o), 32'h06);
    peek(1);
    chk("R10 empty mask data", 32'(rd_data_o), 32'(mix(s + 2)));
    rdy_all_i = 0;
    wait_n(2);
    chk("R6 any policy low", 32'(rdy_no), 0);

    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule